// File: doc/BRIEF.md
# Prescaled Auto-Reload Up Counter

This block is an 8-bit up counter driven by a power-of-two prescaler. The count advances by one on each tick the prescaler emits. When it steps past 0xFF, it loads a software-set reload value in place of zero and raises a one-cycle overflow pulse. The prescaler is fed by one of two sources:

- the system clock, which gives one input tick per cycle;
- an external frequency pin, which is synchronised and edge-detected in the system clock domain.

Software drives the block through a small strobe-based register port. It writes the control bits, the reload value and the counter itself. Reads are combinational. The prescaler is never visible directly. It is cleared whenever software loads the counter, either by writing the counter directly or by forcing a reload, so that counting restarts from a known phase. Clearing the enable bit freezes both the counter and the prescaler. They resume from where they stopped.

Top module: `prc_counter`

## Requirements
- R1: After reset, `count` is 0, `overflow` is 0, the prescaler is cleared, and the control register reads 0 (system clock source, disabled, tap 0).
- R2: While enabled, `count` increases by one on each prescaler tick. A read of address 2 returns the current count.
- R3: A tick that finds the count at 0xFF loads the reload value (address 1) into the counter. The prescaler phase is left as it is.
- R4: `overflow` is high for exactly the cycle in which `count` first shows the reloaded value after a 0xFF step, and is low otherwise.
- R5: While the enable bit (control bit 4) is 0, neither the count nor the prescaler changes. Setting the bit again resumes counting from the frozen prescaler phase.
- R6: The tap field (control bits 2:0) with value n makes one counter tick per 2^n input ticks, for n from 0 to 7.
- R7: A write to address 2 loads the written value into the counter and clears the prescaler.
- R8: A control write with bit 5 set loads the reload value into the counter and clears the prescaler, once. Bit 5 is not stored and reads back as 0.
- R9: A counter write in the same cycle as an overflowing tick wins. The written value is loaded and no overflow pulse is raised.
- R10: With control bit 3 set, input ticks come from `ext_freq_in`. Each rising edge, after a two-flop synchroniser, gives one input tick, so the count steps three clock edges after the pin rises. A level held high gives only one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_freq_in | input | 1 | External frequency input, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 reload, 2 counter |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as the write address |
| rd_data | output | 8 | Combinational read data |
| count | output | 8 | Current counter value |
| overflow | output | 1 | One-cycle pulse on the step from 0xFF to the reload value |

## Verification
The prescaler phase is hidden, so an error in it shows up only as a count step that comes early or late. The error becomes visible within 2^n input ticks of the fault. The bench therefore samples the count on the edge just before and just after each expected step.

Two mechanisms can leave a stale phase behind: freezing and restarting the block, and clearing the prescaler on a counter write. Each is checked by a step that would fall one or two edges later, or earlier, if the phase were wrong.

A bad reload register or a bad overflow decision shows in the very cycle the count leaves 0xFF. In that cycle both the count value and the overflow pulse are compared.

// File: rtl/prc_pkg.sv
package prc_pkg;
    localparam int CNT_W  = 8;
    localparam int SEL_W  = 3;
    localparam int PSC_W  = (1 << SEL_W) - 1;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 2'd2;

    localparam int B_SEL   = 0;
    localparam int B_SRC   = 3;
    localparam int B_EN    = 4;
    localparam int B_FORCE = 5;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             src_ext;
        logic             en;
    } ctrl_t;
endpackage

// File: rtl/prc_edge_sync.sv
module prc_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = async_in;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise = sync_q.s2 & ~sync_q.s3;

    // R10: one detected edge never lasts two cycles
    p_single_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/prc_prescaler.sv
module prc_prescaler #(
    parameter int SEL_W = 3,
    parameter int PSC_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_tick,
    input  logic             enable,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    typedef struct packed {
        logic [PSC_W-1:0] psc;
    } psc_t;

    psc_t             st_d, st_q;
    logic [PSC_W-1:0] mask;
    logic             full;

    always_comb begin
        mask = ~({PSC_W{1'b1}} << sel);
        full = (st_q.psc & mask) == mask;
        tick = in_tick & enable & full & ~clear;
        st_d = st_q;
        if (clear)                  st_d.psc = '0;
        else if (in_tick && enable) st_d.psc = st_q.psc + PSC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !clear) |=> $stable(st_q.psc));
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.psc == '0));
    p_tap_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ((st_q.psc & $past(mask)) == '0));
endmodule

// File: rtl/prc_core.sv
module prc_core
    import prc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              tick,
    output logic [CNT_W-1:0]  rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              overflow,
    output ctrl_t             ctrl,
    output logic              psc_clear
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } core_t;

    core_t core_d, core_q;
    logic  wr_ctrl, wr_rel, wr_cnt, force_ld;

    always_comb begin
        wr_ctrl  = wr_en && (wr_addr == A_CTRL);
        wr_rel   = wr_en && (wr_addr == A_RELOAD);
        wr_cnt   = wr_en && (wr_addr == A_COUNT);
        force_ld = wr_ctrl && wr_data[B_FORCE];

        core_d     = core_q;
        core_d.ovf = 1'b0;
        if (wr_ctrl) begin
            core_d.ctrl.sel     = wr_data[B_SEL +: SEL_W];
            core_d.ctrl.src_ext = wr_data[B_SRC];
            core_d.ctrl.en      = wr_data[B_EN];
        end
        if (wr_rel) core_d.reload = wr_data;
        if (wr_cnt) begin
            core_d.cnt = wr_data;
        end else if (force_ld) begin
            core_d.cnt = core_q.reload;
        end else if (tick) begin
            if (core_q.cnt == '1) begin
                core_d.cnt = core_q.reload;
                core_d.ovf = 1'b1;
            end else begin
                core_d.cnt = core_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[B_SEL +: SEL_W] = core_q.ctrl.sel;
                rd_data[B_SRC]          = core_q.ctrl.src_ext;
                rd_data[B_EN]           = core_q.ctrl.en;
            end
            A_RELOAD: rd_data = core_q.reload;
            A_COUNT:  rd_data = core_q.cnt;
            default:  rd_data = '0;
        endcase
    end

    assign count     = core_q.cnt;
    assign overflow  = core_q.ovf;
    assign ctrl      = core_q.ctrl;
    assign psc_clear = wr_cnt | force_ld;

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !psc_clear && core_q.cnt != '1) |=> (core_q.cnt == $past(core_q.cnt) + CNT_W'(1)));
    p_ovf_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.ovf |-> (core_q.cnt == $past(core_q.reload)));
    p_ovf_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.ovf |-> ($past(core_q.cnt) == '1));
    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_q.ctrl.en && !psc_clear) |=> $stable(core_q.cnt));
    p_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (force_ld && !wr_cnt) |=> (core_q.cnt == $past(core_q.reload)));
    p_write_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (core_q.cnt == $past(wr_data) && !core_q.ovf));
endmodule

// File: rtl/prc_counter.sv
module prc_counter
    import prc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_freq_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              overflow
);
    ctrl_t ctrl;
    logic  ext_rise, in_tick, psc_clear, tick;

    prc_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_freq_in),
        .rise     (ext_rise)
    );

    assign in_tick = ctrl.src_ext ? ext_rise : 1'b1;

    prc_prescaler #(.SEL_W(SEL_W), .PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_tick (in_tick),
        .enable  (ctrl.en),
        .clear   (psc_clear),
        .sel     (ctrl.sel),
        .tick    (tick)
    );

    prc_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .tick      (tick),
        .rd_data   (rd_data),
        .count     (count),
        .overflow  (overflow),
        .ctrl      (ctrl),
        .psc_clear (psc_clear)
    );

    // R10: with the external source picked, counting needs an external edge
    p_ext_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.src_ext && !ext_rise) |-> !tick);
endmodule

// File: tb/tb_prc_counter.sv
module tb_prc_counter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_freq_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data, count;
    logic       overflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    prc_counter dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_freq_in (ext_freq_in),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .count       (count),
        .overflow    (overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // control byte: [2:0] tap, [3] external source, [4] enable, [5] force reload
    function automatic logic [7:0] ctl(input int tap, input bit ext, input bit en, input bit frc);
        return {2'b00, frc, en, ext, 3'(tap)};
    endfunction

    task automatic t_reset_r1();
        rd_addr = 2'd0;
        check("R1 count", count, 0);
        check("R1 overflow", overflow, 0);
        check("R1 ctrl", rd_data, 0);
    endtask

    task automatic t_count_r2();
        reg_write(2'd0, ctl(0, 0, 0, 0));
        reg_write(2'd2, 8'h10);
        reg_write(2'd0, ctl(0, 0, 1, 0));
        clocks(5);
        check("R2 count", count, 8'h15);
        rd_addr = 2'd2;
        #1 check("R2 readback", rd_data, 8'h15);
    endtask

    task automatic t_overflow_r3_r4();
        reg_write(2'd0, ctl(0, 0, 0, 0));
        reg_write(2'd1, 8'h80);
        reg_write(2'd2, 8'hFE);
        reg_write(2'd0, ctl(0, 0, 1, 0));
        clocks(1);
        check("R4 no pulse at FF", overflow, 0);
        check("R2 reaches FF", count, 8'hFF);
        clocks(1);
        check("R3 reload value", count, 8'h80);
        check("R4 pulse", overflow, 1);
        clocks(1);
        check("R4 pulse ends", overflow, 0);
        check("R3 counts on", count, 8'h81);
    endtask

    task automatic t_freeze_r5();
        reg_write(2'd0, ctl(0, 0, 0, 0));
        reg_write(2'd1, 8'h10);
        reg_write(2'd0, ctl(2, 0, 1, 1));
        clocks(6);
        check("R5 before freeze", count, 8'h11);
        reg_write(2'd0, ctl(2, 0, 0, 0));
        clocks(10);
        check("R5 frozen", count, 8'h11);
        reg_write(2'd0, ctl(2, 0, 1, 0));
        check("R5 resume write", count, 8'h11);
        clocks(1);
        check("R5 resumes phase", count, 8'h12);
    endtask

    task automatic t_tap_r6_r8();
        reg_write(2'd0, ctl(0, 0, 0, 0));
        reg_write(2'd1, 8'h50);
        reg_write(2'd0, ctl(3, 0, 1, 1));
        check("R8 force load", count, 8'h50);
        rd_addr = 2'd0;
        #1 check("R8 force bit reads 0", rd_data, 8'h13);
        clocks(39);
        check("R6 divide by 8 before step", count, 8'h54);
        clocks(1);
        check("R6 divide by 8 step", count, 8'h55);
    endtask

    task automatic t_cnt_write_r7();
        reg_write(2'd0, ctl(0, 0, 0, 0));
        reg_write(2'd0, ctl(2, 0, 1, 1));
        clocks(2);
        reg_write(2'd2, 8'h40);
        check("R7 load", count, 8'h40);
        clocks(3);
        check("R7 prescaler cleared", count, 8'h40);
        clocks(1);
        check("R7 first step", count, 8'h41);
    endtask

    task automatic t_prio_r9();
        reg_write(2'd0, ctl(0, 0, 0, 0));
        reg_write(2'd1, 8'h80);
        reg_write(2'd2, 8'hFE);
        reg_write(2'd0, ctl(0, 0, 1, 0));
        clocks(1);
        check("R9 at FF", count, 8'hFF);
        reg_write(2'd2, 8'h33);
        check("R9 write wins", count, 8'h33);
        check("R9 no pulse", overflow, 0);
        clocks(1);
        check("R9 counts on", count, 8'h34);
    endtask

    task automatic t_ext_r10();
        reg_write(2'd0, ctl(0, 0, 0, 0));
        reg_write(2'd1, 8'h20);
        ext_freq_in = 1'b0;
        clocks(4);
        reg_write(2'd0, ctl(0, 1, 1, 1));
        clocks(4);
        check("R10 no system ticks", count, 8'h20);
        ext_freq_in = 1'b1;
        clocks(2);
        check("R10 latency before", count, 8'h20);
        clocks(1);
        check("R10 latency step", count, 8'h21);
        clocks(10);
        check("R10 level gives one tick", count, 8'h21);
        for (int i = 0; i < 2; i++) begin
            ext_freq_in = 1'b0; clocks(4);
            ext_freq_in = 1'b1; clocks(4);
        end
        check("R10 pulse count", count, 8'h23);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset_r1();
        t_count_r2();
        t_overflow_r3_r4();
        t_freeze_r5();
        t_tap_r6_r8();
        t_cnt_write_r7();
        t_prio_r9();
        t_ext_r10();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule